// File: doc/BRIEF.md
# Shared Instruction and Data Word Memory

This block is a single synchronous storage array with two access paths into it. A read-only fetch port returns full 32-bit words for an instruction stream. A data port reads and writes byte, halfword or word quantities, and a 2-bit size code selects which.

Both ports address the same words, so a store through the data port is visible to later fetches. Narrow stores and loads use the most-significant lanes of the addressed word. A store puts a byte in bits [31:24] and a halfword in bits [31:16]. A narrow load takes the same upper lanes and returns them zero-extended.

The fourth size code is reserved. A store made with it changes nothing. A load made with it returns the whole word. Both read ports are registered, so data appears one clock after the address.

Top module: `unified_mem`

## Requirements
- R1: The word index is address bits [IDX_W+1:2], where IDX_W = log2(DEPTH). Address bits [1:0] and the bits above the index are ignored on both ports.
- R2: A data write with size code 2'b00 (byte) stores write data [7:0] into word bits [31:24] and keeps bits [23:0].
- R3: A data write with size code 2'b01 (halfword) stores write data [15:0] into word bits [31:16] and keeps bits [15:0].
- R4: A data write with size code 2'b10 (word) replaces all 32 bits of the word.
- R5: A data write with size code 2'b11 leaves the memory unchanged.
- R6: A data read with size code 2'b00 returns word bits [31:24] in result bits [7:0], with bits [31:8] zero.
- R7: A data read with size code 2'b01 returns word bits [31:16] in result bits [15:0], with bits [31:16] zero.
- R8: A data read with size code 2'b10 or 2'b11 returns the full word.
- R9: The fetch port returns full words from the same storage, in the same cycles as data-port reads and writes.
- R10: Writes take effect on the rising clock edge. Both read outputs are registered: they show the word as it stood just before the edge at which the address was sampled, one clock later.
- R11: While rst_ni is low, both read outputs are zero. Reset leaves the storage contents intact.
- R12: With the write enable low, the memory is unchanged whatever the size code and write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the read outputs |
| imem_addr_i | input | 32 | Fetch byte address |
| dmem_addr_i | input | 32 | Data byte address |
| dmem_wdata_i | input | 32 | Data write value |
| dmem_we_i | input | 1 | Data write enable |
| dmem_size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| imem_rdata_o | output | 32 | Registered fetch word |
| dmem_rdata_o | output | 32 | Registered, zero-extended data read value |

## Verification
The checker examines the lane write mask on every cycle:
- A byte store enables only the top lane and a halfword store only the top two lanes.
- A word store enables all four lanes.
- A reserved-code store, or any cycle with the write enable low, enables none.

The checker also confirms that narrow reads come out with zero upper bits, and that the outputs leave reset at zero.

Some behaviour shows up only in read-back sequences in the bench:
- which bits are kept by a merged store;
- address aliasing;
- the old-value result of a read made in the same cycle as a write;
- sharing of the array between the two ports;
- survival of the contents across a reset.

// File: rtl/unified_mem_pkg.sv
package unified_mem_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/mem_store_align.sv
module mem_store_align
  import unified_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  lane_we_o,
  output logic [DATA_W-1:0] lane_data_o
);
  int unsigned n_lanes;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: n_lanes = 1;
      SZ_HALF: n_lanes = 2;
      SZ_WORD: n_lanes = LANES;
      default: n_lanes = 0;
    endcase
  end

  // narrow data lands in the top lanes
  always_comb begin
    lane_we_o   = '0;
    lane_data_o = '0;
    if (we_i && n_lanes != 0) begin
      for (int l = 0; l < LANES; l++) begin
        lane_we_o[l] = (l >= LANES - n_lanes);
      end
      lane_data_o = wdata_i << ((LANES - n_lanes) * LANE_W);
    end
  end
endmodule

// File: rtl/mem_load_extract.sv
module mem_load_extract
  import unified_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: data_o = word_i >> (DATA_W - LANE_W);
      SZ_HALF: data_o = word_i >> (DATA_W - 2 * LANE_W);
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/mem_word_array.sv
module mem_word_array
  import unified_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] lane_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_word_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_word_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (lane_we_i[l]) mem_q[wr_idx_i][l*LANE_W +: LANE_W] <= lane_data_i[l*LANE_W +: LANE_W];
    end
  end

  assign rd_a_word_o = mem_q[rd_a_idx_i];
  assign rd_b_word_o = mem_q[rd_b_idx_i];
endmodule

// File: rtl/unified_mem.sv
module unified_mem
  import unified_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFF_W = $clog2(LANES),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] imem_addr_i,
  input  logic [ADDR_W-1:0] dmem_addr_i,
  input  logic [DATA_W-1:0] dmem_wdata_i,
  input  logic              dmem_we_i,
  input  logic [1:0]        dmem_size_i,
  output logic [DATA_W-1:0] imem_rdata_o,
  output logic [DATA_W-1:0] dmem_rdata_o
);
  logic [IDX_W-1:0]  d_idx, i_idx;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] lane_data, d_word, i_word, d_ext;

  assign d_idx = dmem_addr_i[OFF_W +: IDX_W];
  assign i_idx = imem_addr_i[OFF_W +: IDX_W];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{dmem_addr_i[ADDR_W-1:OFF_W+IDX_W], dmem_addr_i[OFF_W-1:0],
                              imem_addr_i[ADDR_W-1:OFF_W+IDX_W], imem_addr_i[OFF_W-1:0]};

  mem_store_align #(.DATA_W(DATA_W)) store_i (
    .we_i        (dmem_we_i),
    .size_i      (dmem_size_i),
    .wdata_i     (dmem_wdata_i),
    .lane_we_o   (lane_we),
    .lane_data_o (lane_data)
  );

  mem_word_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) array_i (
    .clk_i       (clk_i),
    .wr_idx_i    (d_idx),
    .lane_we_i   (lane_we),
    .lane_data_i (lane_data),
    .rd_a_idx_i  (d_idx),
    .rd_a_word_o (d_word),
    .rd_b_idx_i  (i_idx),
    .rd_b_word_o (i_word)
  );

  mem_load_extract #(.DATA_W(DATA_W)) load_i (
    .size_i (dmem_size_i),
    .word_i (d_word),
    .data_o (d_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imem_rdata_o <= '0;
      dmem_rdata_o <= '0;
    end else begin
      imem_rdata_o <= i_word;
      dmem_rdata_o <= d_ext;
    end
  end
endmodule

// File: rtl/unified_mem_chk.sv
module unified_mem_chk
  import unified_mem_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dmem_we_i,
  input logic [1:0]        dmem_size_i,
  input logic [LANES-1:0]  lane_we_i,
  input logic [DATA_W-1:0] imem_rdata_o,
  input logic [DATA_W-1:0] dmem_rdata_o
);
  assert_byte_lanes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_i && dmem_size_i == SZ_BYTE) |-> lane_we_i == {1'b1, {(LANES-1){1'b0}}});

  assert_half_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_i && dmem_size_i == SZ_HALF) |-> lane_we_i == {2'b11, {(LANES-2){1'b0}}});

  assert_word_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_i && dmem_size_i == SZ_WORD) |-> lane_we_i == {LANES{1'b1}});

  assert_rsvd_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_size_i == SZ_RSVD) |-> lane_we_i == '0);

  assert_we_low_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dmem_we_i |-> lane_we_i == '0);

  assert_byte_zext_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_size_i == SZ_BYTE) |=> dmem_rdata_o[DATA_W-1:LANE_W] == '0);

  assert_half_zext_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_size_i == SZ_HALF) |=> dmem_rdata_o[DATA_W-1:2*LANE_W] == '0);

  assert_reset_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (imem_rdata_o == '0 && dmem_rdata_o == '0));
endmodule

bind unified_mem unified_mem_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dmem_we_i    (dmem_we_i),
  .dmem_size_i  (dmem_size_i),
  .lane_we_i    (lane_we),
  .imem_rdata_o (imem_rdata_o),
  .dmem_rdata_o (dmem_rdata_o)
);

// File: tb/unified_mem_tb_top.sv
module unified_mem_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr_i = '0, dmem_addr_i = '0, dmem_wdata_i = '0;
  logic        dmem_we_i = 1'b0;
  logic [1:0]  dmem_size_i = 2'b10;
  logic [31:0] imem_rdata_o, dmem_rdata_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  unified_mem dut_i (.*);

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [31:0] da, wd, ia, ed, ei;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 32'h1000, 32'h0, 32'h0000, 32'h11223344, 32'h00000013, 4'd8},  // R8 R9
    '{1'b1, 2'd0, 32'h1000, 32'hDEADBEEF, 32'h0004, 32'h00000011, 32'h00100093, 4'd10}, // R10 old value
    '{1'b0, 2'd2, 32'h1000, 32'h0, 32'h0008, 32'hEF223344, 32'h00200113, 4'd2},  // R2
    '{1'b0, 2'd0, 32'h1000, 32'h0, 32'h000C, 32'h000000EF, 32'h00308193, 4'd6},  // R6
    '{1'b1, 2'd1, 32'h1004, 32'hDEADBEEF, 32'h0000, 32'h00005566, 32'h00000013, 4'd7}, // R7 R10
    '{1'b0, 2'd2, 32'h1004, 32'h0, 32'h0004, 32'hBEEF7788, 32'h00100093, 4'd3},  // R3
    '{1'b0, 2'd1, 32'h1004, 32'h0, 32'h0004, 32'h0000BEEF, 32'h00100093, 4'd7},  // R7
    '{1'b1, 2'd2, 32'h1008, 32'hDEADBEEF, 32'h0004, 32'h99AABBCC, 32'h00100093, 4'd10}, // R10
    '{1'b0, 2'd3, 32'h1008, 32'h0, 32'h0004, 32'hDEADBEEF, 32'h00100093, 4'd4},  // R4 R8
    '{1'b1, 2'd3, 32'h100C, 32'hDEADBEEF, 32'h0004, 32'h0F0E0D0C, 32'h00100093, 4'd5}, // R5
    '{1'b0, 2'd2, 32'h100C, 32'h0, 32'h0004, 32'h0F0E0D0C, 32'h00100093, 4'd5},  // R5
    '{1'b0, 2'd2, 32'hABCD100F, 32'h0, 32'hFFFF0006, 32'h0F0E0D0C, 32'h00100093, 4'd1}, // R1
    '{1'b0, 2'd1, 32'h1000, 32'h0, 32'h0004, 32'h0000EF22, 32'h00100093, 4'd7},  // R7
    '{1'b0, 2'd2, 32'h0000, 32'h0, 32'h1008, 32'h00000013, 32'hDEADBEEF, 4'd9},  // R9
    '{1'b1, 2'd2, 32'h0000, 32'hCAFEF00D, 32'h0000, 32'h00000013, 32'h00000013, 4'd10}, // R10
    '{1'b0, 2'd2, 32'h0000, 32'h0, 32'h0000, 32'hCAFEF00D, 32'hCAFEF00D, 4'd9},  // R9
    '{1'b0, 2'd2, 32'h1008, 32'h12345678, 32'h0008, 32'hDEADBEEF, 32'h00200113, 4'd12}, // R12
    '{1'b0, 2'd2, 32'h1008, 32'h0, 32'h0008, 32'hDEADBEEF, 32'h00200113, 4'd12}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] d);
    dmem_we_i = 1'b1; dmem_size_i = 2'b10; dmem_addr_i = a; dmem_wdata_i = d;
    @(negedge clk_i);
    dmem_we_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #3;
    check("R11", imem_rdata_o, 32'h0);
    check("R11", dmem_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr_word(32'h1000, 32'h11223344);
    wr_word(32'h1004, 32'h55667788);
    wr_word(32'h1008, 32'h99AABBCC);
    wr_word(32'h100C, 32'h0F0E0D0C);
    wr_word(32'h0000, 32'h00000013);
    wr_word(32'h0004, 32'h00100093);
    wr_word(32'h0008, 32'h00200113);
    wr_word(32'h000C, 32'h00308193);
    for (int k = 0; k < NV; k++) begin
      dmem_we_i = VECS[k].we; dmem_size_i = VECS[k].sz; dmem_addr_i = VECS[k].da;
      dmem_wdata_i = VECS[k].wd; imem_addr_i = VECS[k].ia;
      @(negedge clk_i);
      check($sformatf("R%0d data vec %0d", VECS[k].rq, k), dmem_rdata_o, VECS[k].ed);
      check($sformatf("R%0d fetch vec %0d", VECS[k].rq, k), imem_rdata_o, VECS[k].ei);
    end
    dmem_we_i = 1'b0;
    // R11: asynchronous clear mid-run, contents kept
    dmem_size_i = 2'b10; dmem_addr_i = 32'h1008; imem_addr_i = 32'h1004;
    #1 rst_ni = 1'b0;
    #0.5;
    check("R11 data cleared", dmem_rdata_o, 32'h0);
    check("R11 fetch cleared", imem_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 data retained", dmem_rdata_o, 32'hDEADBEEF);
    check("R11 fetch retained", imem_rdata_o, 32'hBEEF7788);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule